// File: doc/BRIEF.md
# Triggered Pipeline Readout Controller

This block sequences the digital side of a triggered front-end readout. A circular sample pipeline of 256 columns is written on every bunch-crossing clock; the block drives its write column and, when a level-0 trigger arrives, works out which column holds the sample taken a fixed latency earlier. That column number goes into a small derandomizer queue, so bursts of closely spaced triggers are absorbed. The trigger input is registered inside the block before it is used.

The queue is drained one event at a time. Each event is sent as a 16-bit header followed by one sample word per channel. The header carries the column number, so downstream logic can check synchronisation. Output is spread over one or more ports that run in parallel. During the data phase the block drives a column and word index toward external sample storage and forwards the returned words unchanged. A valid strobe marks every header and data clock. A trigger that finds the queue full is dropped and flagged.

Top module: `trig_readout_ctrl`

## Requirements
- R1: `wr_col` is 0 in the first cycle after reset and advances by one on every clock, wrapping from 255 to 0.
- R2: A trigger high in the cycle where `wr_col` equals W queues column (W − LATENCY) mod 256. LATENCY defaults to 160. This column appears in the event's header and on `rd_col` for the whole data phase.
- R3: Events leave in trigger order, one per accepted trigger. When the queue is empty and no event is running, `dv` first goes high in the cycle after the third rising edge counted from the edge that samples the trigger.
- R4: The queue holds Q_DEPTH (16) columns, so 16 or more consecutive triggers are accepted without loss.
- R5: A trigger that reaches the queue while it holds Q_DEPTH entries is discarded, and `ovf` is high for one cycle. The entry of a starting event is freed on that event's first clock.
- R6: The header is sent first. Bits 0 to 15, in transmission order, are: 1; even parity of the column (the XOR of its bits); `edc_flag`; `reg_par[0]`, `reg_par[1]`, `reg_par[2]`; `seu_lsb[0]`, `seu_lsb[1]`; then the column from bit 7 down to bit 0. Port p sends header bits p·H to p·H+H−1 on header clocks 0 to H−1, with H = 16/N_PORTS. Each header word has the bit in bit 0 and zeros above it.
- R7: An event lasts 16/N_PORTS + N_CHAN/N_PORTS clocks (36 with the defaults), with `dv` high for exactly those clocks. A queued event starts on the clock right after the previous event ends, with no gap.
- R8: On data clock k, `rd_idx` = k and port p carries `rd_data` slice p. This slice holds channel p·(N_CHAN/N_PORTS)+k of column `rd_col`.
- R9: During and after reset, `dv`, `ovf`, `dout` and `wr_col` are 0, and queued events are discarded.
- R10: `dout` is zero in every cycle where `dv` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Level-0 trigger, one pulse per clock |
| edc_flag | input | 1 | Status bit placed in the header |
| reg_par | input | 3 | Configuration parity bits for the header |
| seu_lsb | input | 2 | Low bits of the upset counter for the header |
| rd_data | input | N_PORTS·SAMP_W | Sample words returned by storage, one slice per port |
| wr_col | output | 8 | Pipeline column written this clock |
| rd_col | output | 8 | Column of the event being read |
| rd_idx | output | log2(N_CHAN/N_PORTS) | Word index within each port's channel group |
| dout | output | N_PORTS·SAMP_W | Port output words |
| dv | output | 1 | High on header and data clocks |
| ovf | output | 1 | One-cycle pulse when a trigger is dropped |

## Verification
Some properties are checked on every clock. The queue is never popped while empty. `ovf` only follows a full queue. Every queued column trails the write column by exactly the latency. `dv` only falls on an event's final clock. The bench's scenarios cover the rest: the header bit order and parity, the channel-to-port mapping of the data, trigger ordering across bursts, the exact start delay, the back-to-back chaining of a full queue, and the flush on reset. These are only visible by comparing whole events against columns that the bench predicts from its own cycle count.

// File: rtl/tro_pkg.sv
package tro_pkg;
   localparam int PCN_W     = 8;
   localparam int COL_DEPTH = 1 << PCN_W;
   localparam int HDR_BITS  = 16;

   // Header bit i is the i-th bit sent.
   function automatic logic [HDR_BITS-1:0] tro_make_hdr(
      input logic [PCN_W-1:0] col,
      input logic             edc,
      input logic [2:0]       rp,
      input logic [1:0]       seu);
      logic [HDR_BITS-1:0] h;
      h[0]   = 1'b1;
      h[1]   = ^col;
      h[2]   = edc;
      h[5:3] = rp;
      h[7:6] = seu;
      for (int i = 0; i < PCN_W; i++) h[8+i] = col[PCN_W-1-i];
      return h;
   endfunction
endpackage

// File: rtl/tro_trig_stage.sv
module tro_trig_stage
   import tro_pkg::*;
#(
   parameter int LATENCY = 160
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_in,
   output logic [PCN_W-1:0] wr_col,
   output logic             push,
   output logic [PCN_W-1:0] push_col
);
   localparam logic [PCN_W-1:0] LAT_MOD = PCN_W'(LATENCY % COL_DEPTH);

   if (LATENCY < 1 || LATENCY >= COL_DEPTH) begin : g_bad_lat
      $error("LATENCY must lie inside the pipeline depth");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_col   <= '0;
         push     <= 1'b0;
         push_col <= '0;
      end else begin
         wr_col   <= wr_col + 1'b1;
         push     <= trig_in;
         push_col <= wr_col - LAT_MOD;
      end
   end

   // R2: a queued column trails the (already advanced) write column by LATENCY+1
   p_col_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (push_col == PCN_W'(wr_col - LAT_MOD - 1'b1)));
endmodule

// File: rtl/tro_derand.sv
module tro_derand #(
   parameter int DEPTH = 16,
   parameter int W     = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         ovf
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          full, accept;

   assign full   = (cnt == CW'(DEPTH));
   assign empty  = (cnt == '0);
   assign accept = push && !full;
   assign dout   = mem[rp];

   always_ff @(posedge clk) begin
      if (accept) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         if (accept) wp <= wp + 1'b1;
         if (pop)    rp <= rp + 1'b1;
         cnt <= cnt + CW'(accept) - CW'(pop);
         ovf <= push && full;
      end
   end

   // R3: the reader never takes an entry that is not there
   p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R4: occupancy stays within the queue depth
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   // R5: a drop flag only ever follows a full queue
   p_ovf_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> $past(cnt) == CW'(DEPTH));
endmodule

// File: rtl/tro_serializer.sv
module tro_serializer
   import tro_pkg::*;
#(
   parameter int N_PORTS = 4,
   parameter int N_CHAN  = 128,
   parameter int SAMP_W  = 8
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        q_empty,
   input  logic [PCN_W-1:0]            q_col,
   output logic                        q_pop,
   input  logic                        edc_flag,
   input  logic [2:0]                  reg_par,
   input  logic [1:0]                  seu_lsb,
   input  logic [N_PORTS*SAMP_W-1:0]   rd_data,
   output logic [PCN_W-1:0]            rd_col,
   output logic [$clog2(N_CHAN/N_PORTS)-1:0] rd_idx,
   output logic [N_PORTS*SAMP_W-1:0]   dout,
   output logic                        dv
);
   localparam int HDR_CLK = HDR_BITS / N_PORTS;
   localparam int DAT_CLK = N_CHAN / N_PORTS;
   localparam int EV_LEN  = HDR_CLK + DAT_CLK;
   localparam int CW      = $clog2(EV_LEN);
   localparam int IW      = $clog2(DAT_CLK);
   localparam int HW      = (HDR_CLK > 1) ? $clog2(HDR_CLK) : 1;

   if (HDR_BITS % N_PORTS != 0 || N_CHAN % N_PORTS != 0 || DAT_CLK < 2 || SAMP_W < 2)
   begin : g_bad_geom
      $error("port count must divide header and channel counts");
   end

   logic                busy, last, start, in_hdr;
   logic [CW-1:0]       pos, didx;
   logic [HDR_BITS-1:0] hdr;

   assign last   = busy && (pos == CW'(EV_LEN - 1));
   assign start  = !q_empty && (!busy || last);
   assign q_pop  = start;
   assign in_hdr = pos < CW'(HDR_CLK);
   assign didx   = pos - CW'(HDR_CLK);
   assign rd_idx = didx[IW-1:0];
   assign dv     = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         pos    <= '0;
         rd_col <= '0;
         hdr    <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         pos    <= '0;
         rd_col <= q_col;
         hdr    <= tro_make_hdr(q_col, edc_flag, reg_par, seu_lsb);
      end else if (last) begin
         busy <= 1'b0;
         pos  <= '0;
      end else if (busy) begin
         pos <= pos + 1'b1;
      end
   end

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic hb;
      if (HDR_CLK == 1) begin : g_one
         assign hb = hdr[p];
      end else begin : g_many
         logic [HDR_CLK-1:0] seg;
         assign seg = hdr[p*HDR_CLK +: HDR_CLK];
         assign hb  = seg[pos[HW-1:0]];
      end
      assign dout[p*SAMP_W +: SAMP_W] = !busy  ? '0 :
                                        in_hdr ? {{(SAMP_W-1){1'b0}}, hb} :
                                                 rd_data[p*SAMP_W +: SAMP_W];
   end

   // R7: the strobe only ends on the final clock of an event
   p_event_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dv) |-> $past(pos) == CW'(EV_LEN - 1));
   // R10: idle output is quiet
   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !dv |-> dout == '0);
endmodule

// File: rtl/trig_readout_ctrl.sv
module trig_readout_ctrl
   import tro_pkg::*;
#(
   parameter int LATENCY = 160,
   parameter int Q_DEPTH = 16,
   parameter int N_PORTS = 4,
   parameter int N_CHAN  = 128,
   parameter int SAMP_W  = 8
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              trig,
   input  logic                              edc_flag,
   input  logic [2:0]                        reg_par,
   input  logic [1:0]                        seu_lsb,
   input  logic [N_PORTS*SAMP_W-1:0]         rd_data,
   output logic [PCN_W-1:0]                  wr_col,
   output logic [PCN_W-1:0]                  rd_col,
   output logic [$clog2(N_CHAN/N_PORTS)-1:0] rd_idx,
   output logic [N_PORTS*SAMP_W-1:0]         dout,
   output logic                              dv,
   output logic                              ovf
);
   logic             push, q_pop, q_empty;
   logic [PCN_W-1:0] push_col, q_col;

   tro_trig_stage #(.LATENCY(LATENCY)) u_trig (
      .clk(clk), .rst_n(rst_n), .trig_in(trig),
      .wr_col(wr_col), .push(push), .push_col(push_col));

   tro_derand #(.DEPTH(Q_DEPTH), .W(PCN_W)) u_q (
      .clk(clk), .rst_n(rst_n), .push(push), .din(push_col),
      .pop(q_pop), .dout(q_col), .empty(q_empty), .ovf(ovf));

   tro_serializer #(.N_PORTS(N_PORTS), .N_CHAN(N_CHAN), .SAMP_W(SAMP_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_col(q_col), .q_pop(q_pop),
      .edc_flag(edc_flag), .reg_par(reg_par), .seu_lsb(seu_lsb),
      .rd_data(rd_data), .rd_col(rd_col), .rd_idx(rd_idx), .dout(dout), .dv(dv));
endmodule

// File: tb/trig_readout_ctrl_bench.sv
`timescale 1ns/100ps
module trig_readout_ctrl_bench;
   localparam int LAT = 160, NP = 4, NCH = 128, SW = 8;
   localparam int HC = 16 / NP, DC = NCH / NP, EVL = HC + DC;
   // stimulus table: burst length and idle clocks after it
   localparam int NUM [12] = '{1, 3, 1, 2, 1, 5, 1, 1, 4, 1, 2, 1};
   localparam int GAP [12] = '{5, 0, 40, 100, 0, 3, 80, 37, 0, 10, 60, 2};

   logic clk = 0, rst_n = 0, trig = 0;
   logic edc = 1'b1;
   logic [2:0] rp = 3'b110;
   logic [1:0] seu = 2'b01;
   logic [NP*SW-1:0] rd_data, dout;
   logic [7:0] wr_col, rd_col;
   logic [$clog2(DC)-1:0] rd_idx;
   logic dv, ovf;

   int checks = 0, errors = 0;
   int ncyc = 0, erd = 0, ewr = 0, pos = 0, events = 0, falls = 0, ovf_cnt = 0, idle_bad = 0;
   logic [7:0] exp_col [64];
   logic [7:0] ecol;
   logic [15:0] gh, eh;
   int dbad;
   logic [7:0] dact, dexp;
   logic dv_d = 0;

   trig_readout_ctrl u_trig_readout_ctrl (
      .clk(clk), .rst_n(rst_n), .trig(trig), .edc_flag(edc), .reg_par(rp),
      .seu_lsb(seu), .rd_data(rd_data), .wr_col(wr_col), .rd_col(rd_col),
      .rd_idx(rd_idx), .dout(dout), .dv(dv), .ovf(ovf));

   always #2.5 clk = ~clk;

   always_comb
      for (int p = 0; p < NP; p++)
         rd_data[p*SW +: SW] = 8'(int'(rd_col) * 3 + p * DC + int'(rd_idx));

   always @(posedge clk or negedge rst_n)
      if (!rst_n) ncyc <= 0; else ncyc <= ncyc + 1;

   function automatic logic [15:0] hdr_of(input logic [7:0] c);
      logic [15:0] h;
      h[0] = 1'b1; h[1] = ^c; h[2] = edc; h[5:3] = rp; h[7:6] = seu;
      for (int i = 0; i < 8; i++) h[8+i] = c[7-i];
      return h;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // event monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         pos = 0;
      end else begin
         if (ovf) ovf_cnt++;
         if (!dv && dout != '0) idle_bad++;
         if (dv_d && !dv) begin
            falls++;
            check(pos == 0, "R7 strobe length", pos, 0);
         end
         if (!dv && pos != 0) pos = 0;
         if (dv) begin
            if (pos == 0) begin
               if (erd == ewr) begin
                  check(0, "R3 unexpected event", events, ewr);
                  ecol = 8'h00;
               end else begin
                  ecol = exp_col[erd % 64];
                  erd++;
               end
               gh = '0; dbad = 0; dact = 0; dexp = 0;
            end
            for (int p = 0; p < NP; p++) begin
               if (pos < HC) begin
                  gh[p*HC + pos] = dout[p*SW];
                  if (dout[p*SW+1 +: SW-1] != '0) dbad++;
               end else begin
                  if (dout[p*SW +: SW] != 8'(int'(ecol)*3 + p*DC + pos - HC)) begin
                     if (dbad == 0) begin
                        dact = dout[p*SW +: SW];
                        dexp = 8'(int'(ecol)*3 + p*DC + pos - HC);
                     end
                     dbad++;
                  end
                  if (rd_col != ecol) dbad++;
               end
            end
            pos++;
            if (pos == EVL) begin
               eh = hdr_of(ecol);
               events++;
               check(gh[15:8] == eh[15:8], "R2 column in header", gh[15:8], eh[15:8]);
               check(gh[7:0] == eh[7:0], "R6 header bits", gh[7:0], eh[7:0]);
               check(dbad == 0, "R8 data words", dact, dexp);
               pos = 0;
            end
         end
      end
      dv_d = dv && rst_n;
   end

   task automatic burst(input int n, input int keep);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         trig = 1'b1;
         if (i < keep) begin
            exp_col[ewr % 64] = 8'(ncyc - LAT);
            ewr++;
         end
      end
      @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (erd == ewr && !dv && pos == 0) break;
      end
   endtask

   initial begin
      #500000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", events, ewr);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int ev0, f0, o0;
      repeat (3) @(negedge clk);
      check(!dv && !ovf && dout == '0 && wr_col == 0, "R9 reset state", wr_col, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(int'(wr_col) == (ncyc % 256) && ncyc == 5, "R1 write column", wr_col, ncyc % 256);
      repeat (300) @(negedge clk);
      check(int'(wr_col) == (ncyc % 256), "R1 wrap", wr_col, ncyc % 256);

      for (int v = 0; v < 12; v++) begin
         burst(NUM[v], NUM[v]);
         repeat (GAP[v]) @(negedge clk);
      end
      drain();
      check(erd == ewr, "R3 all events delivered", erd, ewr);

      // R3 start delay
      @(negedge clk);
      trig = 1'b1;
      exp_col[ewr % 64] = 8'(ncyc - LAT); ewr++;
      @(negedge clk); trig = 1'b0;
      check(!dv, "R3 no early strobe 1", dv, 0);
      @(negedge clk);
      check(!dv, "R3 no early strobe 2", dv, 0);
      @(negedge clk);
      check(dv, "R3 strobe after three edges", dv, 1);
      drain();

      // R4 / R5: 18 back-to-back triggers, the 18th finds a full queue
      ev0 = events; f0 = falls; o0 = ovf_cnt;
      burst(18, 17);
      drain();
      check(events - ev0 == 17, "R4 burst accepted", events - ev0, 17);
      check(ovf_cnt - o0 == 1, "R5 overflow pulse", ovf_cnt - o0, 1);
      check(falls - f0 == 1, "R7 events chained without gap", falls - f0, 1);

      // R9: reset in the middle of an event flushes the queue
      burst(3, 3);
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      erd = ewr;
      @(negedge clk);
      check(!dv && !ovf && dout == '0 && wr_col == 0, "R9 reset mid event", dv, 0);
      repeat (2) @(negedge clk);
      ev0 = events;
      rst_n = 1'b1;
      repeat (100) @(negedge clk);
      check(events == ev0 && !dv, "R9 queue flushed", events - ev0, 0);
      check(idle_bad == 0, "R10 idle output zero", idle_bad, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule